// File: doc/BRIEF.md
# Label-Indexed Receive Word Manager

This block collects finished 32-bit receive words from up to eight serial receive channels and keeps a table holding the latest word for every label of every channel. The label is the low byte of the word. Each word is stored at the slot whose word address is the channel number joined with the label, `{channel, label}`. A host with byte addressing adds a two-bit byte index below that address. The table is 2048 words deep, which is 8 KiB in total.

A filter table holds two enable bits for every slot. When a word arrives, the filter can raise a host interrupt, copy the word into a 32-entry queue for that channel, do both, or do neither. The table slot is always overwritten whatever the filter says. Only one word is accepted per cycle. When several channels offer words in the same cycle, the lowest-numbered channel wins and the others wait on their ready lines. The interrupt stays high until the host acknowledges it, and it reports which slot raised it.

Top module: `label_rx_mgr`

## Requirements
- R1: After reset, `irq` is 0, `irq_src` is 0, every bit of `q_empty` is 1, every bit of `q_overflow` is 0, and `rx_ready` is 0 while no `rx_valid` is set.
- R2: `rx_ready` is one-hot or zero. It marks the lowest-numbered channel that has `rx_valid` set, and exactly that channel's word is taken at the next clock edge.
- R3: An accepted word is written to slot `{channel, word[7:0]}`, replacing the previous word in that slot. A read with `tbl_rd_en` returns the slot's word on `tbl_rd_data` one cycle later.
- R4: When a table read and a word write address the same slot in the same cycle, the read returns the contents from before the write.
- R5: Filter entries reset to 0. A filter write sets bit 0 (interrupt enable, `flt_irq_en`) and bit 1 (queue enable, `flt_fifo_en`) for one slot. A word arriving in the same cycle as a filter write to its own slot is judged by the old entry.
- R6: A word whose slot has interrupt enable set drives `irq` to 1 in the following cycle. `irq` then stays at 1 until a cycle in which `irq_ack` is 1.
- R7: `irq_src` holds `{channel, label}` of the word that raised the pending interrupt. Later interrupt words do not change it while it is pending. An acknowledge with no new interrupt word in that cycle clears `irq` and `irq_src` to 0.
- R8: If an acknowledge and a new interrupt word fall in the same cycle, `irq` stays at 1 and `irq_src` takes the new word's slot.
- R9: A word whose slot has queue enable set is appended to its channel's queue. `q_data` shows the head of the queue chosen by `q_sel`. `q_pop` removes that head, and words leave in arrival order.
- R10: A queue holds 32 words. A queued word arriving when its queue is full is discarded from the queue and sets that channel's `q_overflow` bit, which stays at 1 until reset. The table slot is still updated.
- R11: A word whose filter entry is 0 changes only its table slot: `irq` is not raised and no queue gains an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 8 | Per-channel word-offered flags |
| rx_word | input | 256 | Channel words; channel c occupies bits [32c+31:32c] |
| rx_ready | output | 8 | Per-channel acceptance (one-hot) |
| flt_we | input | 1 | Filter entry write strobe |
| flt_addr | input | 11 | Filter slot {channel, label} |
| flt_irq_en | input | 1 | Filter bit 0: interrupt enable |
| flt_fifo_en | input | 1 | Filter bit 1: queue enable |
| tbl_rd_en | input | 1 | Table read strobe |
| tbl_rd_addr | input | 11 | Table slot {channel, label} to read |
| tbl_rd_data | output | 32 | Read word, one cycle after strobe |
| q_pop | input | 1 | Remove head of selected queue |
| q_sel | input | 3 | Queue selector |
| q_data | output | 32 | Head word of selected queue |
| q_empty | output | 8 | Per-channel queue empty |
| q_overflow | output | 8 | Per-channel sticky queue overflow |
| irq | output | 1 | Pending interrupt |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_src | output | 11 | {channel, label} of pending interrupt |

## Verification
An acknowledge from the host and the arrival of a new interrupt-enabled word can happen in the same clock cycle. The bench forces this case: it leaves one interrupt pending, then drives `irq_ack` in the same cycle as a word for a different interrupt-enabled slot. It then expects `irq` to stay high and `irq_src` to show the new slot, not zero. A host table read and a word write to the same slot also meet in a single cycle. In that case the bench expects the old word on `tbl_rd_data`, then reads again and expects the new one.

// File: rtl/lrm_pkg.sv
package lrm_pkg;
  // Filter entry: bit 0 raises the interrupt, bit 1 copies into the queue.
  typedef struct packed {
    logic to_fifo;
    logic to_irq;
  } flt_t;
endpackage

// File: rtl/lrm_arbiter.sv
module lrm_arbiter #(
  parameter int N    = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             any
);
  // Lowest index wins.
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i]  = 1'b1;
        gnt_idx = IDX_W'(i);
        any     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lrm_table.sv
module lrm_table #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Registered read sees pre-write contents on a same-slot collision.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/lrm_filter.sv
module lrm_filter
  import lrm_pkg::*;
#(
  parameter int ADDR_W = 11,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  flt_t              wdata,
  input  logic [ADDR_W-1:0] raddr,
  output flt_t              rdata
);
  flt_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lrm_fifo.sv
module lrm_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         drop,
  output logic         ovf
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             full, do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign drop    = push && full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (drop) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/lrm_irq.sv
module lrm_irq #(
  parameter int SRC_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic [SRC_W-1:0] set_src,
  input  logic             ack,
  output logic             irq,
  output logic [SRC_W-1:0] src
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
      src <= '0;
    end else if (set && (!irq || ack)) begin
      irq <= 1'b1;
      src <= set_src;
    end else if (ack) begin
      irq <= 1'b0;
      src <= '0;
    end
  end
endmodule

// File: rtl/label_rx_mgr.sv
module label_rx_mgr
  import lrm_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int WORD_W     = 32,
  parameter int LBL_W      = 8,
  parameter int FIFO_DEPTH = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SLOT_W = CH_W + LBL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        rx_valid,
  input  logic [NUM_CH*WORD_W-1:0] rx_word,
  output logic [NUM_CH-1:0]        rx_ready,
  input  logic                     flt_we,
  input  logic [SLOT_W-1:0]        flt_addr,
  input  logic                     flt_irq_en,
  input  logic                     flt_fifo_en,
  input  logic                     tbl_rd_en,
  input  logic [SLOT_W-1:0]        tbl_rd_addr,
  output logic [WORD_W-1:0]        tbl_rd_data,
  input  logic                     q_pop,
  input  logic [CH_W-1:0]          q_sel,
  output logic [WORD_W-1:0]        q_data,
  output logic [NUM_CH-1:0]        q_empty,
  output logic [NUM_CH-1:0]        q_overflow,
  output logic                     irq,
  input  logic                     irq_ack,
  output logic [SLOT_W-1:0]        irq_src
);
  // Slot index: channel above label.
  function automatic logic [SLOT_W-1:0] slot_of(input logic [CH_W-1:0] ch,
                                                input logic [WORD_W-1:0] w);
    return {ch, w[LBL_W-1:0]};
  endfunction

  // Named internal events.
  logic                     acc_valid;
  logic [CH_W-1:0]          acc_ch;
  logic [WORD_W-1:0]        acc_word;
  logic [SLOT_W-1:0]        acc_slot;
  flt_t                     acc_flt;
  logic                     acc_irq, acc_fifo;
  logic [NUM_CH-1:0]        q_push, q_drop;
  logic [NUM_CH-1:0][WORD_W-1:0] q_heads;
  flt_t                     flt_wr;

  lrm_arbiter #(.N(NUM_CH)) u_arb (
    .req(rx_valid), .gnt(rx_ready), .gnt_idx(acc_ch), .any(acc_valid)
  );

  assign acc_word = rx_word[acc_ch*WORD_W +: WORD_W];
  assign acc_slot = slot_of(acc_ch, acc_word);
  assign acc_irq  = acc_valid && acc_flt.to_irq;
  assign acc_fifo = acc_valid && acc_flt.to_fifo;
  assign flt_wr   = '{to_fifo: flt_fifo_en, to_irq: flt_irq_en};

  lrm_filter #(.ADDR_W(SLOT_W)) u_flt (
    .clk(clk), .rst_n(rst_n), .we(flt_we), .waddr(flt_addr), .wdata(flt_wr),
    .raddr(acc_slot), .rdata(acc_flt)
  );

  lrm_table #(.ADDR_W(SLOT_W), .DATA_W(WORD_W)) u_tbl (
    .clk(clk), .wr_en(acc_valid), .wr_addr(acc_slot), .wr_data(acc_word),
    .rd_en(tbl_rd_en), .rd_addr(tbl_rd_addr), .rd_data(tbl_rd_data)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_q
    assign q_push[c] = acc_fifo && (acc_ch == CH_W'(c));
    lrm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .push(q_push[c]), .wdata(acc_word),
      .pop(q_pop && (q_sel == CH_W'(c))), .head(q_heads[c]),
      .empty(q_empty[c]), .drop(q_drop[c]), .ovf(q_overflow[c])
    );
  end

  assign q_data = q_heads[q_sel];

  lrm_irq #(.SRC_W(SLOT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(acc_irq), .set_src(acc_slot),
    .ack(irq_ack), .irq(irq), .src(irq_src)
  );
endmodule

// File: rtl/lrm_checker.sv
module lrm_checker #(
  parameter int NUM_CH = 8,
  parameter int SLOT_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] rx_valid,
  input logic [NUM_CH-1:0] rx_ready,
  input logic              acc_valid,
  input logic              acc_irq,
  input logic [SLOT_W-1:0] acc_slot,
  input logic [NUM_CH-1:0] q_drop,
  input logic [NUM_CH-1:0] q_overflow,
  input logic              irq,
  input logic              irq_ack,
  input logic [SLOT_W-1:0] irq_src
);
  assert_ready_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_ready));
  assert_ready_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready & ~rx_valid) == '0);
  assert_irq_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_irq |=> irq);
  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_ack |=> irq);
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !acc_irq |=> !irq && irq_src == '0);
  assert_src_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_irq && (!irq || irq_ack) |=> irq_src == $past(acc_slot));
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q_overflow != '0 |=> (q_overflow & $past(q_overflow)) == $past(q_overflow));
  for (genvar c = 0; c < NUM_CH; c++) begin : g_drop
    assert_drop_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
      q_drop[c] |=> q_overflow[c]);
  end
  assert_accept_when_offered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid != '0) |-> acc_valid);
endmodule

bind label_rx_mgr lrm_checker #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .acc_valid(acc_valid), .acc_irq(acc_irq), .acc_slot(acc_slot),
  .q_drop(q_drop), .q_overflow(q_overflow), .irq(irq), .irq_ack(irq_ack),
  .irq_src(irq_src)
);

// File: tb/test_label_rx_mgr.sv
module test_label_rx_mgr;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [7:0]   rx_valid;
  logic [255:0] rx_word;
  logic [7:0]   rx_ready;
  logic         flt_we, flt_irq_en, flt_fifo_en, tbl_rd_en, q_pop, irq, irq_ack;
  logic [10:0]  flt_addr, tbl_rd_addr, irq_src;
  logic [31:0]  tbl_rd_data, q_data;
  logic [2:0]   q_sel;
  logic [7:0]   q_empty, q_overflow;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  label_rx_mgr i_label_rx_mgr (.*);

  // Reference model
  logic [31:0] exp_tbl [0:2047];
  logic [1:0]  exp_flt [0:2047];
  logic [31:0] exp_q   [0:7][$];
  logic [7:0]  exp_ovf = '0;
  logic [31:0] rd_q [$];
  string       rd_tag [$];
  logic        rd_d = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] slot(input int ch, input logic [7:0] lbl);
    return {3'(ch), lbl};
  endfunction

  task automatic model_accept(input int ch, input logic [31:0] w);
    logic [10:0] s;
    s = slot(ch, w[7:0]);
    exp_tbl[s] = w;
    if (exp_flt[s][1]) begin
      if (exp_q[ch].size() < 32) exp_q[ch].push_back(w);
      else exp_ovf[ch] = 1'b1;
    end
  endtask

  task automatic send(input int ch, input logic [31:0] w);
    rx_valid = 8'(1 << ch);
    rx_word = '0;
    rx_word[ch*32 +: 32] = w;
    @(negedge clk);
    rx_valid = '0;
    model_accept(ch, w);
  endtask

  task automatic set_flt(input int ch, input logic [7:0] lbl, input logic ie, input logic fe);
    flt_we = 1'b1; flt_addr = slot(ch, lbl); flt_irq_en = ie; flt_fifo_en = fe;
    @(negedge clk);
    flt_we = 1'b0;
    exp_flt[slot(ch, lbl)] = {fe, ie};
  endtask

  // Driver pushes expected read data; monitor compares when it appears.
  task automatic rd(input int ch, input logic [7:0] lbl, input string tag);
    rd_q.push_back(exp_tbl[slot(ch, lbl)]);
    rd_tag.push_back(tag);
    tbl_rd_en = 1'b1; tbl_rd_addr = slot(ch, lbl);
    @(negedge clk);
    tbl_rd_en = 1'b0;
  endtask

  always @(posedge clk) rd_d <= tbl_rd_en;

  always @(negedge clk) begin
    if (rd_d && rd_q.size() > 0) chk(rd_tag.pop_front(), tbl_rd_data, rd_q.pop_front());
  end

  task automatic pop(input int ch, input string tag);
    q_sel = 3'(ch);
    #1;
    chk(tag, q_data, exp_q[ch].pop_front());
    q_pop = 1'b1;
    @(negedge clk);
    q_pop = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #600000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin exp_tbl[i] = '0; exp_flt[i] = '0; end
    rst_n = 1'b0; rx_valid = '0; rx_word = '0; flt_we = 0; flt_addr = '0;
    flt_irq_en = 0; flt_fifo_en = 0; tbl_rd_en = 0; tbl_rd_addr = '0;
    q_pop = 0; q_sel = '0; irq_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 irq_src", 32'(irq_src), 0);
    chk("R1 q_empty", 32'(q_empty), 32'hff);
    chk("R1 q_overflow", 32'(q_overflow), 0);
    chk("R1 rx_ready idle", 32'(rx_ready), 0);

    // R11 / R5: unprogrammed filter -> table only
    send(0, 32'h1234_5607);
    chk("R11 no irq", 32'(irq), 0);
    chk("R11 queue empty", 32'(q_empty), 32'hff);
    send(7, 32'hCAFE_0055);
    chk("R5 reset filter no irq", 32'(irq), 0);
    rd(0, 8'h07, "R3 table read");
    send(0, 32'hABCD_EF07);
    rd(0, 8'h07, "R3 latest wins");
    rd(7, 8'h55, "R3 other channel");

    // R2 priority among channels 1, 3, 6
    rx_valid = 8'b0100_1010; rx_word = '0;
    rx_word[1*32 +: 32] = 32'h1111_0010;
    rx_word[3*32 +: 32] = 32'h3333_0030;
    rx_word[6*32 +: 32] = 32'h6666_0060;
    #1 chk("R2 grant ch1", 32'(rx_ready), 32'h02);
    @(negedge clk); model_accept(1, 32'h1111_0010); rx_valid[1] = 1'b0;
    #1 chk("R2 grant ch3", 32'(rx_ready), 32'h08);
    @(negedge clk); model_accept(3, 32'h3333_0030); rx_valid[3] = 1'b0;
    #1 chk("R2 grant ch6", 32'(rx_ready), 32'h40);
    @(negedge clk); model_accept(6, 32'h6666_0060); rx_valid = '0;
    rd(1, 8'h10, "R2 ch1 stored");
    rd(3, 8'h30, "R2 ch3 stored");
    rd(6, 8'h60, "R2 ch6 stored");

    // R6 / R7 interrupt
    set_flt(2, 8'h31, 1, 0);
    set_flt(5, 8'hA0, 1, 1);
    send(2, 32'h0000_0131);
    chk("R6 irq raised", 32'(irq), 1);
    chk("R7 src", 32'(irq_src), 32'(slot(2, 8'h31)));
    send(5, 32'h0000_05A0);
    chk("R7 src kept", 32'(irq_src), 32'(slot(2, 8'h31)));
    repeat (3) @(negedge clk);
    chk("R6 irq held", 32'(irq), 1);
    ack();
    chk("R7 ack clears irq", 32'(irq), 0);
    chk("R7 ack clears src", 32'(irq_src), 0);

    // R8 ack coinciding with new interrupt word
    send(2, 32'h0000_0231);
    irq_ack = 1'b1;
    rx_valid = 8'h20; rx_word = '0; rx_word[5*32 +: 32] = 32'h0000_06A0;
    @(negedge clk);
    irq_ack = 1'b0; rx_valid = '0; model_accept(5, 32'h0000_06A0);
    chk("R8 irq stays", 32'(irq), 1);
    chk("R8 src new", 32'(irq_src), 32'(slot(5, 8'hA0)));
    ack();

    // R5 filter write coinciding with arrival uses old entry
    flt_we = 1'b1; flt_addr = slot(4, 8'h44); flt_irq_en = 1; flt_fifo_en = 0;
    rx_valid = 8'h10; rx_word = '0; rx_word[4*32 +: 32] = 32'h0000_0044;
    @(negedge clk);
    flt_we = 1'b0; rx_valid = '0;
    model_accept(4, 32'h0000_0044);
    exp_flt[slot(4, 8'h44)] = 2'b01;
    chk("R5 old entry used", 32'(irq), 0);
    send(4, 32'h0000_0144);
    chk("R5 new entry used", 32'(irq), 1);
    ack();

    // R9 queue order (channel 5 holds two words already)
    chk("R9 ch5 not empty", 32'(q_empty[5]), 0);
    pop(5, "R9 first");
    pop(5, "R9 second");
    chk("R9 ch5 empty", 32'(q_empty[5]), 1);

    // R10 overflow on channel 2
    set_flt(2, 8'h32, 0, 1);
    for (int i = 0; i < 33; i++) send(2, {8'(i), 16'h5A5A, 8'h32});
    chk("R10 overflow flag", 32'(q_overflow), 32'h04);
    rd(2, 8'h32, "R10 table still updated");
    for (int i = 0; i < 32; i++) pop(2, "R10 queued order");
    chk("R10 empty after drain", 32'(q_empty[2]), 1);
    chk("R10 sticky", 32'(q_overflow), 32'(exp_ovf));

    // R4 read/write collision on same slot
    rd_q.push_back(exp_tbl[slot(0, 8'h07)]);
    rd_tag.push_back("R4 collision old data");
    tbl_rd_en = 1'b1; tbl_rd_addr = slot(0, 8'h07);
    rx_valid = 8'h01; rx_word = '0; rx_word[31:0] = 32'h7777_7707;
    @(negedge clk);
    tbl_rd_en = 1'b0; rx_valid = '0;
    model_accept(0, 32'h7777_7707);
    rd(0, 8'h07, "R4 new data after");
    @(negedge clk);

    summary();
    $finish;
  end
endmodule